// File: doc/BRIEF.md
# Timer Channel Control Bank

This block is the control bank of an eight-channel timer unit. It holds four groups of per-channel control state: counter enables, counter stops, event flags and event masks. Software reaches each group through three word locations on a 32-bit register bus. One location reads the current state. One location sets every bit written as 1. One location clears every bit written as 1. Software never has to do a read-modify-write, so two agents that each own different channels cannot overwrite each other's bits.

Each counter channel sends two single-cycle event pulses into the bank: one when the count reaches the full compare value and one when it reaches the half compare value. The bank latches each pulse as a sticky flag. Full-match flags sit in the low half of the flag word and half-match flags sit in the high half, and the mask word uses the same layout. A channel's interrupt line is driven from its two flags, each gated by its own mask. Software acknowledges an interrupt by writing the channel's bit to the clear-flag location. The enable and stop state is also driven straight out to the counters.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset, the enable, stop and flag state are all 0. Every implemented mask bit is 1, so the mask status reads 0x00FF00FF. All `ch_irq`, `ch_enable` and `ch_stop` outputs are 0.
- R2: The enable state reads at offset 0x010. A write to 0x014 sets every bit n (0..7) that is written as 1, and a write to 0x018 clears every such bit. `ch_enable[n]` follows enable bit n.
- R3: The stop state reads at offset 0x01c. A write to 0x02c sets bits and a write to 0x03c clears bits, in the same way as R2. `ch_stop[n]` follows stop bit n.
- R4: Any bit written as 0 to a set or clear location leaves the matching state bit unchanged.
- R5: A pulse on `ch_full_evt[n]` sets flag bit n, and a pulse on `ch_half_evt[n]` sets flag bit 16+n. Both flags stay set after the pulse ends.
- R6: The flag state reads at 0x020. A write to 0x024 sets flags and a write to 0x028 clears them, using the same bit positions as R5.
- R7: The mask state reads at 0x030. A write to 0x034 sets mask bits and a write to 0x038 clears them. Full-match masks are at bit n and half-match masks are at bit 16+n.
- R8: `ch_irq[n]` is 1 exactly when (full flag n is 1 and full mask n is 0) or (half flag n is 1 and half mask n is 0). It changes in the cycle after the flag or mask register it depends on is updated.
- R9: If an event pulse and a clear-flag write reach the same flag bit in the same cycle, the flag ends up set.
- R10: The following read as 0: enable and stop bits 8..31, flag and mask bits 8..15 and 24..31, every set or clear location, and every unmapped offset. Writes to those bits or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ch_full_evt | input | 8 | Full-match event pulse for each channel |
| ch_half_evt | input | 8 | Half-match event pulse for each channel |
| ch_enable | output | 8 | Counter enable for each channel |
| ch_stop | output | 8 | Counter stop for each channel |
| ch_irq | output | 8 | Interrupt request for each channel |

## Verification
The assertions assume that a bus write hits at most one location per cycle, so at most one write strobe is active in any cycle. They also assume that event pulses and the bus act only on the implemented channel bits. The stimulus issues one access per cycle. It drives events only when it wants them, for a single cycle at a time, and it places reserved-bit writes deliberately so that their lack of effect can be read back through the status locations. The race between a hardware event and a clear-flag write is set up on purpose, with both arriving in the same cycle.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_POS = 16;

    localparam logic [7:0] OFS_EN_STAT   = 8'h10;
    localparam logic [7:0] OFS_EN_SET    = 8'h14;
    localparam logic [7:0] OFS_EN_CLR    = 8'h18;
    localparam logic [7:0] OFS_STOP_STAT = 8'h1c;
    localparam logic [7:0] OFS_STOP_SET  = 8'h2c;
    localparam logic [7:0] OFS_STOP_CLR  = 8'h3c;
    localparam logic [7:0] OFS_FLAG_STAT = 8'h20;
    localparam logic [7:0] OFS_FLAG_SET  = 8'h24;
    localparam logic [7:0] OFS_FLAG_CLR  = 8'h28;
    localparam logic [7:0] OFS_MASK_STAT = 8'h30;
    localparam logic [7:0] OFS_MASK_SET  = 8'h34;
    localparam logic [7:0] OFS_MASK_CLR  = 8'h38;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic stop_set;
        logic stop_clr;
        logic flag_set;
        logic flag_clr;
        logic mask_set;
        logic mask_clr;
    } wr_stb_t;

endpackage

// File: rtl/tmr_ctl_setclr.sv
module tmr_ctl_setclr #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    input  logic [W-1:0] hw_v,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] raise;

    always_comb begin
        raise     = set_v | hw_v;
        st_d.bits = (st_q.bits | raise) & ~(clr_v & ~raise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign q = st_q.bits;

    // A raised bit is 1 in the next cycle, even against a clear (R9, R5)
    p_raise_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raise != '0) |=> ((q & $past(raise)) == $past(raise)));

    // A clear with no competing set drops the bit (R4)
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_v & ~raise) != '0) |=> ((q & $past(clr_v & ~raise)) == '0));

    // With no set, clear or event, the state holds (R4)
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v == '0 && clr_v == '0 && hw_v == '0) |=> $stable(q));

endmodule

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_ctl_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCH-1:0]    en_q,
    input  logic [NCH-1:0]    stop_q,
    input  logic [2*NCH-1:0]  flag_q,
    input  logic [2*NCH-1:0]  mask_q,
    output wr_stb_t           stb,
    output logic [DATA_W-1:0] rdata
);

    function automatic logic [DATA_W-1:0] place_pair(input logic [2*NCH-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NCH-1:0]        = v[NCH-1:0];
        w[HALF_POS +: NCH] = v[2*NCH-1:NCH];
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] place_low(input logic [NCH-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NCH-1:0] = v;
        return w;
    endfunction

    always_comb begin
        stb = '0;
        if (sel && wr) begin
            unique case (addr)
                OFS_EN_SET[ADDR_W-1:0]:   stb.en_set   = 1'b1;
                OFS_EN_CLR[ADDR_W-1:0]:   stb.en_clr   = 1'b1;
                OFS_STOP_SET[ADDR_W-1:0]: stb.stop_set = 1'b1;
                OFS_STOP_CLR[ADDR_W-1:0]: stb.stop_clr = 1'b1;
                OFS_FLAG_SET[ADDR_W-1:0]: stb.flag_set = 1'b1;
                OFS_FLAG_CLR[ADDR_W-1:0]: stb.flag_clr = 1'b1;
                OFS_MASK_SET[ADDR_W-1:0]: stb.mask_set = 1'b1;
                OFS_MASK_CLR[ADDR_W-1:0]: stb.mask_clr = 1'b1;
                default:                  stb          = '0;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            OFS_EN_STAT[ADDR_W-1:0]:   rdata = place_low(en_q);
            OFS_STOP_STAT[ADDR_W-1:0]: rdata = place_low(stop_q);
            OFS_FLAG_STAT[ADDR_W-1:0]: rdata = place_pair(flag_q);
            OFS_MASK_STAT[ADDR_W-1:0]: rdata = place_pair(mask_q);
            default:                   rdata = '0;
        endcase
    end

    // One bus access selects at most one write location (R2, R3, R6, R7)
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // Reserved read positions stay zero whatever the state holds (R10)
    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[HALF_POS-1:NCH] == '0) && (rdata[DATA_W-1:HALF_POS+NCH] == '0));

endmodule

// File: rtl/tmr_ctl_irq.sv
module tmr_ctl_irq #(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*NCH-1:0] flag_q,
    input  logic [2*NCH-1:0] mask_q,
    output logic [NCH-1:0]   irq
);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic full_live, half_live;
        assign full_live = flag_q[n]       & ~mask_q[n];
        assign half_live = flag_q[NCH + n] & ~mask_q[NCH + n];
        assign irq[n]    = full_live | half_live;
    end

    // No request without a latched flag behind it (R8)
    p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~(flag_q[NCH-1:0] | flag_q[2*NCH-1:NCH])) == '0));

    // With every source masked, no request is raised (R8)
    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> (irq == '0));

endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
    import tmr_ctl_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    ch_full_evt,
    input  logic [NCH-1:0]    ch_half_evt,
    output logic [NCH-1:0]    ch_enable,
    output logic [NCH-1:0]    ch_stop,
    output logic [NCH-1:0]    ch_irq
);

    localparam int PAIR_W = 2 * NCH;

    wr_stb_t           stb;
    logic [NCH-1:0]    en_q, stop_q;
    logic [PAIR_W-1:0] flag_q, mask_q;
    logic [NCH-1:0]    low_bits;
    logic [PAIR_W-1:0] pair_bits, evt_pair;

    assign low_bits  = bus_wdata[NCH-1:0];
    assign pair_bits = {bus_wdata[HALF_POS +: NCH], bus_wdata[NCH-1:0]};
    assign evt_pair  = {ch_half_evt, ch_full_evt};

    tmr_ctl_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .en_q   (en_q),
        .stop_q (stop_q),
        .flag_q (flag_q),
        .mask_q (mask_q),
        .stb    (stb),
        .rdata  (bus_rdata)
    );

    tmr_ctl_setclr #(.W(NCH), .RST_VAL('0)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (stb.en_set ? low_bits : '0),
        .clr_v (stb.en_clr ? low_bits : '0),
        .hw_v  ('0),
        .q     (en_q)
    );

    tmr_ctl_setclr #(.W(NCH), .RST_VAL('0)) u_stop (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (stb.stop_set ? low_bits : '0),
        .clr_v (stb.stop_clr ? low_bits : '0),
        .hw_v  ('0),
        .q     (stop_q)
    );

    tmr_ctl_setclr #(.W(PAIR_W), .RST_VAL('0)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (stb.flag_set ? pair_bits : '0),
        .clr_v (stb.flag_clr ? pair_bits : '0),
        .hw_v  (evt_pair),
        .q     (flag_q)
    );

    tmr_ctl_setclr #(.W(PAIR_W), .RST_VAL('1)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (stb.mask_set ? pair_bits : '0),
        .clr_v (stb.mask_clr ? pair_bits : '0),
        .hw_v  ('0),
        .q     (mask_q)
    );

    tmr_ctl_irq #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_q (flag_q),
        .mask_q (mask_q),
        .irq    (ch_irq)
    );

    assign ch_enable = en_q;
    assign ch_stop   = stop_q;

    // Counter controls mirror the enable and stop state (R2, R3)
    p_ctrl_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.stop_set && bus_wdata[0]) |=> ch_stop[0]);

    // An event on a channel leaves that channel's flag visible on the bus word (R5)
    p_event_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_full_evt[0] && bus_addr == OFS_FLAG_STAT[ADDR_W-1:0]
         && $stable(bus_addr)) |=> bus_rdata[0]);

endmodule

// File: tb/tb_tmr_ctl_bank.sv
module tb_tmr_ctl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ch_full_evt = '0;
    logic [7:0]  ch_half_evt = '0;
    logic [7:0]  ch_enable, ch_stop, ch_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_ctl_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ch_full_evt (ch_full_evt),
        .ch_half_evt (ch_half_evt),
        .ch_enable   (ch_enable),
        .ch_stop     (ch_stop),
        .ch_irq      (ch_irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  fev;
        logic [7:0]  hev;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic [7:0]  exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{8'h14, 32'h0000_00A5, 8'h00, 8'h00, 8'h10, 32'h0000_00A5, 8'h00, 8'd2},  // R2 set
        '{8'h14, 32'h0000_0102, 8'h00, 8'h00, 8'h10, 32'h0000_00A7, 8'h00, 8'd4},  // R4 zeros keep, R10 bit 8 dropped
        '{8'h18, 32'h0000_0021, 8'h00, 8'h00, 8'h10, 32'h0000_0086, 8'h00, 8'd2},  // R2 clear
        '{8'h2c, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h1c, 32'h0000_00FF, 8'h00, 8'd3},  // R3 set, R10 upper dropped
        '{8'h3c, 32'h0000_000F, 8'h00, 8'h00, 8'h1c, 32'h0000_00F0, 8'h00, 8'd3},  // R3 clear
        '{8'h00, 32'hFFFF_FFFF, 8'h03, 8'h80, 8'h20, 32'h0080_0003, 8'h00, 8'd5},  // R5 events, R10 unmapped write
        '{8'h38, 32'h0000_0001, 8'h00, 8'h00, 8'h30, 32'h00FF_00FE, 8'h01, 8'd7},  // R7 unmask full0, R8
        '{8'h38, 32'h0080_0000, 8'h00, 8'h00, 8'h30, 32'h007F_00FE, 8'h81, 8'd8},  // R8 half7 unmasked
        '{8'h28, 32'h0000_0001, 8'h00, 8'h00, 8'h20, 32'h0080_0002, 8'h80, 8'd6},  // R6 ack full0
        '{8'h24, 32'h0001_0000, 8'h00, 8'h00, 8'h20, 32'h0081_0002, 8'h80, 8'd6},  // R6 sw set half0 (masked)
        '{8'h34, 32'h0080_0000, 8'h00, 8'h00, 8'h30, 32'h00FF_00FE, 8'h00, 8'd7},  // R7 remask half7
        '{8'h28, 32'hFFFF_FFFF, 8'h00, 8'h00, 8'h20, 32'h0000_0000, 8'h00, 8'd6}   // R6 clear all
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input logic [31:0] d,
                          input logic [7:0] fev, input logic [7:0] hev);
        @(negedge clk);
        bus_sel     = 1'b1;
        bus_wr      = 1'b1;
        bus_addr    = a;
        bus_wdata   = d;
        ch_full_evt = fev;
        ch_half_evt = hev;
        @(negedge clk);
        bus_sel     = 1'b0;
        bus_wr      = 1'b0;
        ch_full_evt = '0;
        ch_half_evt = '0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, $sformatf("read 0x%02h", a), bus_rdata, exp);
    endtask

    initial begin
        #(10 * 5000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_chk("R1", 8'h10, 32'h0);
        read_chk("R1", 8'h1c, 32'h0);
        read_chk("R1", 8'h20, 32'h0);
        read_chk("R1", 8'h30, 32'h00FF_00FF);
        check("R1", "irq", {24'h0, ch_irq}, 32'h0);
        check("R1", "enable", {24'h0, ch_enable}, 32'h0);
        check("R1", "stop", {24'h0, ch_stop}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i].waddr, VEC[i].wdata, VEC[i].fev, VEC[i].hev);
            read_chk($sformatf("R%0d", VEC[i].req), VEC[i].raddr, VEC[i].exp_rd);
            check($sformatf("R%0d", VEC[i].req), $sformatf("irq vec %0d", i),
                  {24'h0, ch_irq}, {24'h0, VEC[i].exp_irq});
        end

        // R2, R3 counter control outputs follow the state
        check("R2", "ch_enable", {24'h0, ch_enable}, 32'h86);
        check("R3", "ch_stop", {24'h0, ch_stop}, 32'hF0);

        // R9 event against clear-flag write on the same bit
        access(8'h38, 32'h0000_00FF, 8'h00, 8'h00);
        access(8'h28, 32'h0000_0004, 8'h04, 8'h00);
        read_chk("R9", 8'h20, 32'h0000_0004);
        check("R9", "irq after race", {24'h0, ch_irq}, 32'h04);
        access(8'h28, 32'h0000_0004, 8'h00, 8'h00);
        read_chk("R9", 8'h20, 32'h0);
        check("R8", "irq after ack", {24'h0, ch_irq}, 32'h0);

        // R10 reserved bits and write-only locations
        access(8'h24, 32'hFF00_FF00, 8'h00, 8'h00);
        read_chk("R10", 8'h20, 32'h0);
        check("R10", "irq reserved", {24'h0, ch_irq}, 32'h0);
        read_chk("R10", 8'h14, 32'h0);
        read_chk("R10", 8'h3c, 32'h0);
        read_chk("R10", 8'h04, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule